// File: doc/BRIEF.md
# Shared-Conversion Sequential Reader for Serial ADCs

This block is a host-side sequencer for a bank of 16-bit serial converters that share one conversion-start line, one serial clock and one tri-stated data return line, while each converter has a private active-low select. On a start request it raises the conversion-start line with every select held high. This launches a simultaneous conversion on all devices and places each of them in chip-select read mode. The block then waits a fixed worst-case conversion interval, long enough that no device ever signals busy.

After the wait, the devices are read strictly one after another. For each device, the block pulls its select low, which puts that device's most significant bit on the shared line. It then toggles the serial clock sixteen times and samples the data line at every falling clock edge. After the sixteenth falling edge it releases the select. The captured word is presented for one cycle with a valid strobe and the index of the device it came from. Once the last word has been delivered, the conversion-start line drops. An acquisition interval follows before a new start is accepted.

The serial clock half-period, the conversion wait, the acquisition interval and the number of devices are all parameters counted in system clock cycles.

Top module: `multi_adc_reader`

## Requirements
- R1: A start request is taken only in the idle state, and the conversion-start output rises one cycle after it is taken. A request made while a frame runs or during the acquisition interval has no effect on any output.
- R2: Every select line is high in the cycle in which the conversion-start output rises.
- R3: The conversion-start output and the busy output are high together, from the taken start until the last word's valid cycle, where both are low.
- R4: No select goes low during the first CONV_CYC cycles after the conversion-start output rises. The first device's select falls exactly CONV_CYC cycles after that rise.
- R5: At most one select line is low at any time. Devices are selected in ascending index order, starting at 0.
- R6: The serial clock is low whenever no device is selected. Each high phase and each low phase lasts SCK_HALF cycles, and the first rising edge comes SCK_HALF cycles after the select falls.
- R7: Each word is assembled from 16 samples of the data line, taken at the 16 falling clock edges, with the first sample placed in bit 15 (MSB first).
- R8: The valid output is a one-cycle pulse in the cycle right after the 16th falling edge. It carries the word on the data output and the device index on the channel output.
- R9: The select is released in the same cycle as the valid pulse. The next device's select falls SCK_HALF cycles later, with the clock held low in between.
- R10: After the last word, the block spends ACQ_CYC cycles unable to start, then returns to idle and accepts a start in its first idle cycle.
- R11: After reset, conversion-start, busy, serial clock and valid are low, and every select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one conversion-and-read frame |
| busy_o | output | 1 | High while a frame is in progress |
| cnv_o | output | 1 | Shared conversion-start line to all converters |
| sel_n_o | output | N_DEV | Per-device active-low select; bit k goes to device k |
| sck_o | output | 1 | Shared serial clock, idles low |
| sdo_i | input | 1 | Shared serial data return from the converters |
| word_o | output | DATA_W | Captured result, meaningful while word_vld_o is high |
| chan_o | output | CH_W | Index of the device that word_o came from |
| word_vld_o | output | 1 | One-cycle strobe marking a delivered word |

## Verification
The bench builds the reader with three devices, a two-cycle clock half-period, a 20-cycle conversion wait and a 5-cycle acquisition interval. With three devices, the bench sees a middle device whose frame sits between two inter-device gaps, and the channel field is wider than one bit. The short waits let several frames run back to back. They also put start requests inside the conversion phase and inside the acquisition interval, and a start in the very first idle cycle. Behavioural converter models return all-zero, all-one, single-bit and mixed patterns, so that bit order and the last-sample timing are both exposed.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_LEAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_GAP   = 3'd4,
    ST_ACQ   = 3'd5
  } rd_state_e;

endpackage

// File: rtl/rd_rst_sync.sv
module rd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/rd_timer.sv
module rd_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R6: the phase counter advances by exactly one per cycle unless reloaded
  p_tmr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/rd_shift.sv
module rd_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          sdo,
  output logic [DW-1:0] word
);

  logic [DW-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (smp_en) sh_d = {sh_q[DW-2:0], sdo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word = sh_q;

  // R7: a sample moves the previous content up by one place
  p_shift_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> (sh_q[DW-1:1] == $past(sh_q[DW-2:0])));

endmodule

// File: rtl/rd_sel_dec.sv
module rd_sel_dec #(
  parameter int ND = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_nxt,
  input  logic [IW-1:0] idx_nxt,
  output logic [ND-1:0] sel_n
);

  logic [ND-1:0] sel_n_d, sel_n_q;

  for (genvar g = 0; g < ND; g++) begin : g_line
    assign sel_n_d[g] = !(en_nxt && (idx_nxt == IW'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_n_q <= '1;
    else        sel_n_q <= sel_n_d;
  end

  assign sel_n = sel_n_q;

  // R5: never more than one device selected
  p_one_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n_q));

endmodule

// File: rtl/multi_adc_reader.sv
module multi_adc_reader
  import adc_rd_pkg::*;
#(
  parameter int N_DEV    = 2,
  parameter int DATA_W   = 16,
  parameter int SCK_HALF = 2,
  parameter int CONV_CYC = 160,
  parameter int ACQ_CYC  = 40,
  parameter int CH_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              cnv_o,
  output logic [N_DEV-1:0]  sel_n_o,
  output logic              sck_o,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] word_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              word_vld_o
);

  localparam int TMAX0 = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
  localparam int TMAX  = (TMAX0 > SCK_HALF) ? TMAX0 : SCK_HALF;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int BW    = $clog2(DATA_W);

  logic rst_sn;

  rd_state_e       st_q, st_d;
  logic [CH_W-1:0] dev_q, dev_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic            sck_q, sck_d;
  logic            cnv_q, cnv_d;
  logic            vld_q, vld_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic            sel_on_q, sel_on_d;
  logic            t_load, t_done, smp_en;
  logic [TW-1:0]   t_val;

  rd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rd_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  rd_shift #(.DW(DATA_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_sn),
    .smp_en (smp_en),
    .sdo    (sdo_i),
    .word   (word_o)
  );

  rd_sel_dec #(.ND(N_DEV), .IW(CH_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en_nxt  (sel_on_d),
    .idx_nxt (dev_d),
    .sel_n   (sel_n_o)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    dev_d    = dev_q;
    bit_d    = bit_q;
    sck_d    = sck_q;
    cnv_d    = cnv_q;
    vld_d    = 1'b0;
    chan_d   = chan_q;
    sel_on_d = sel_on_q;
    t_load   = 1'b0;
    t_val    = '0;
    smp_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_CONV;
          cnv_d  = 1'b1;
          dev_d  = '0;
          t_load = 1'b1;
          t_val  = TW'(CONV_CYC - 1);
        end
      end
      ST_CONV: begin
        if (t_done) begin
          st_d     = ST_LEAD;
          sel_on_d = 1'b1;
          t_load   = 1'b1;
          t_val    = TW'(SCK_HALF - 1);
        end
      end
      ST_LEAD: begin
        if (t_done) begin
          st_d   = ST_SHIFT;
          sck_d  = 1'b1;
          bit_d  = '0;
          t_load = 1'b1;
          t_val  = TW'(SCK_HALF - 1);
        end
      end
      ST_SHIFT: begin
        if (t_done) begin
          t_load = 1'b1;
          t_val  = TW'(SCK_HALF - 1);
          if (sck_q) begin
            sck_d  = 1'b0;
            smp_en = 1'b1;
            if (bit_q == BW'(DATA_W - 1)) begin
              sel_on_d = 1'b0;
              vld_d    = 1'b1;
              chan_d   = dev_q;
              if (dev_q == CH_W'(N_DEV - 1)) begin
                st_d  = ST_ACQ;
                cnv_d = 1'b0;
                t_val = TW'(ACQ_CYC - 1);
              end else begin
                st_d = ST_GAP;
              end
            end else begin
              bit_d = bit_q + BW'(1);
            end
          end else begin
            sck_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (t_done) begin
          st_d     = ST_LEAD;
          dev_d    = dev_q + CH_W'(1);
          sel_on_d = 1'b1;
          t_load   = 1'b1;
          t_val    = TW'(SCK_HALF - 1);
        end
      end
      ST_ACQ: begin
        if (t_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q     <= ST_IDLE;
      dev_q    <= '0;
      bit_q    <= '0;
      sck_q    <= 1'b0;
      cnv_q    <= 1'b0;
      vld_q    <= 1'b0;
      chan_q   <= '0;
      sel_on_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      dev_q    <= dev_d;
      bit_q    <= bit_d;
      sck_q    <= sck_d;
      cnv_q    <= cnv_d;
      vld_q    <= vld_d;
      chan_q   <= chan_d;
      sel_on_q <= sel_on_d;
    end
  end

  assign busy_o     = (st_q != ST_IDLE) && (st_q != ST_ACQ);
  assign cnv_o      = cnv_q;
  assign sck_o      = sck_q;
  assign chan_o     = chan_q;
  assign word_vld_o = vld_q;

  // R1: a start taken in idle raises the conversion line next cycle
  p_idle_start_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_IDLE && start_i) |=> $rose(cnv_o));

  // R2: conversion begins with all selects high
  p_cnv_rise_sel_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(cnv_o) |-> (&sel_n_o));

  // R3: conversion line and busy track each other
  p_cnv_busy_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_o == cnv_o));

  // R4: no select during the conversion wait
  p_conv_nosel_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_CONV) |-> (&sel_n_o));

  // R6: serial clock only toggles with a device selected
  p_sck_sel_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    sck_o |-> !(&sel_n_o));

  // R8: valid is a single-cycle pulse
  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    word_vld_o |=> !word_vld_o);

  // R9: select already released when a word is presented
  p_vld_desel_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    word_vld_o |-> (&sel_n_o));

  // R3: last word ends the busy window
  p_last_word_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (word_vld_o && chan_o == CH_W'(N_DEV - 1)) |-> (!busy_o && !cnv_o));

  // R10: no return to conversion straight out of acquisition
  p_acq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_ACQ) |=> !cnv_o);

endmodule

// File: tb/sim_multi_adc_reader.sv
module sim_multi_adc_reader;

  localparam int N    = 3;
  localparam int H    = 2;
  localparam int C    = 20;
  localparam int A    = 5;
  localparam int DW   = 16;
  localparam int CW   = 2;
  localparam int F    = 33 * H;
  localparam int TEND = C + (N - 1) * F + 32 * H;
  localparam int TIDL = TEND + A;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          busy_o, cnv_o, sck_o, sdo_i, word_vld_o;
  logic [N-1:0]  sel_n_o;
  logic [DW-1:0] word_o;
  logic [CW-1:0] chan_o;

  int n_run, n_fail;
  int t;
  logic [DW-1:0] dat [N];

  multi_adc_reader #(
    .N_DEV(N), .DATA_W(DW), .SCK_HALF(H), .CONV_CYC(C), .ACQ_CYC(A)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .cnv_o(cnv_o), .sel_n_o(sel_n_o), .sck_o(sck_o), .sdo_i(sdo_i),
    .word_o(word_o), .chan_o(chan_o), .word_vld_o(word_vld_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural converters on the shared line
  int   falls;
  logic prev_sck;
  always @(negedge clk) begin
    if (&sel_n_o)               falls <= 0;
    else if (prev_sck && !sck_o) falls <= falls + 1;
    prev_sck <= sck_o;
  end

  always_comb begin
    sdo_i = 1'b0;
    for (int k = 0; k < N; k++)
      if (!sel_n_o[k] && falls < DW) sdo_i = dat[k][DW-1-falls];
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0d)", req, what, act, exp, t);
    end
  endtask

  task automatic model(input int tt, output logic ecnv, output logic esck,
                       output logic evld, output logic [N-1:0] esel, output int ech);
    int r, d, u;
    ecnv = 1'b0; esck = 1'b0; evld = 1'b0; esel = '1; ech = -1;
    if (tt < 0) return;
    if (tt < C) begin ecnv = 1'b1; return; end
    if (tt >= TEND) begin
      evld = (tt == TEND);
      ech  = N - 1;
      return;
    end
    ecnv = 1'b1;
    r = tt - C; d = r / F; u = r % F;
    ech = d;
    if (u < H) esel[d] = 1'b0;
    else if (u < 32 * H) begin
      esel[d] = 1'b0;
      esck    = (((u - H) / H) % 2) == 0;
    end else evld = (u == 32 * H);
  endtask

  task automatic step(input logic st);
    logic ecnv, esck, evld;
    logic [N-1:0] esel;
    int ech;
    @(negedge clk);
    model(t, ecnv, esck, evld, esel, ech);
    if (t < 0)          chk("R11", "idle cnv", cnv_o, 0);
    else if (t < C + 1) chk("R4", "cnv during wait", cnv_o, ecnv);
    else                chk("R3", "cnv", cnv_o, ecnv);
    chk("R3", "busy", busy_o, ecnv);
    if (t >= 0 && t < C + H + 1) chk("R4", "sel", sel_n_o, esel);
    else if (t >= TEND)          chk("R10", "sel in acq", sel_n_o, esel);
    else                         chk("R5", "sel", sel_n_o, esel);
    chk("R6", "sck", sck_o, esck);
    chk("R8", "valid", word_vld_o, evld);
    if (evld && word_vld_o) begin
      chk("R7", "word", word_o, dat[ech]);
      chk("R8", "chan", chan_o, ech);
    end
    start_i = st;
    if (t < 0) t = st ? 0 : -1;
    else       t = (t + 1 == TIDL) ? -1 : t + 1;
  endtask

  task automatic frame(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] c, input int poke1, input int poke2);
    dat[0] = a; dat[1] = b; dat[2] = c;
    step(1'b1);
    while (t != -1) step((t == poke1) || (t == poke2));
    step(1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: cycles=20000 expected completion earlier");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; t = -1;
    rst_n = 1'b0; start_i = 1'b0;
    dat[0] = '0; dat[1] = '0; dat[2] = '0;
    for (int i = 0; i < 4; i++) step(1'b0);   // R11 reset state
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0);
    frame(16'hA5C3, 16'h3C5A, 16'h0F1E, -5, -5);                 // R7 mixed
    frame(16'h8000, 16'h0001, 16'h7FFE, 3, C + 40);             // R1 start while busy
    frame(16'hFFFF, 16'h0000, 16'hFFFF, TEND + 1, TEND + 3);    // R10 start in acq
    // R10 back-to-back: start in first idle cycle
    dat[0] = 16'h1234; dat[1] = 16'hFEDC; dat[2] = 16'h8001;
    step(1'b1);
    while (t != -1) step(1'b0);
    step(1'b1);
    while (t != -1) step(1'b0);
    for (int i = 0; i < 4; i++) step(1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule